// File: doc/BRIEF.md
# Bus Access Violation Monitor

This block sits beside a processor-memory bus and only listens. On each cycle where the bus strobe is valid it reads the access kind (instruction fetch, data read or data write), the address and the data word. It then checks that access against a programmable memory map: an instruction region, a data region, a read-only region and an allowed address window. For fetches it also checks the opcode field of the fetched word against a legality mask. It never drives the bus.

When an access breaks the map, the monitor raises a sticky error flag and stores a 3-bit code that names the class of violation, along with the offending address. Only the first violation is kept. Any later violation, while the flag is still set, only sets an overflow bit. Software or a supervisor loads the map while the monitor is held in configuration mode. It then drops to monitoring mode and clears the flag explicitly after handling an error.

Top module: `bus_guard`

## Requirements
- R1: After reset, err_flag and err_overflow are 0, err_code is 0 and err_addr is 0.
- R2: A fetch (bus_kind 0) whose address lies inside the data region gives code 3.
- R3: A data read (bus_kind 1 or 3) or a data write (bus_kind 2) whose address lies inside the instruction region gives code 4.
- R4: An access whose address lies in none of the instruction, data or read-only regions gives code 1. Each region spans base to limit inclusive, and a region with base greater than limit is empty.
- R5: A write into the read-only region gives code 5. Reads of that region are accepted.
- R6: A fetch is checked for opcode legality. The opcode is the top OPW bits of bus_data, and bit k of the legality mask set to 1 makes opcode k legal. A fetch of an opcode whose mask bit is 0 gives code 6.
- R7: An access whose address lies outside the allowed window (base to limit inclusive) gives code 2.
- R8: When several violations hold in one cycle, the smallest code is recorded.
- R9: A violation with err_flag low sets err_flag, err_code and err_addr one clock after the sampled cycle. While err_flag stays set, later violations leave the code and address unchanged and set err_overflow.
- R10: err_clear zeroes err_flag, err_code, err_addr and err_overflow. A violation sampled in the same cycle as err_clear is recorded as a fresh first violation, with overflow 0.
- R11: A cycle with bus_valid low is never checked.
- R12: Configuration registers load on cfg_we only while cfg_mode is 1. cfg_sel selects the register: 0/1 instruction base/limit, 2/3 data base/limit, 4/5 read-only base/limit, 6/7 allowed base/limit, 8 opcode mask. cfg_we has no effect while cfg_mode is 0, and bus cycles are not checked while cfg_mode is 1. After reset every region is empty and the mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 1 | 1 = configuration mode, 0 = monitoring mode |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 4 | Configuration register select |
| cfg_data | input | AW | Configuration write data |
| bus_valid | input | 1 | Bus cycle strobe |
| bus_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| bus_addr | input | AW | Bus address |
| bus_data | input | DW | Bus data word |
| err_clear | input | 1 | Clear the recorded error |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 3 | Code of the first violation |
| err_addr | output | AW | Address of the first violation |
| err_overflow | output | 1 | A further violation occurred while the flag was set |

## Verification
Clearing and capture can happen in the same cycle. The bench provokes this by asserting err_clear on the same edge where a violating bus cycle is sampled, while an older error with overflow set is still held. The expected result is the new code and address with overflow 0, and none of the old state. Priority is judged the same way. A single access that meets several conditions at once (unpopulated, outside the window and carrying an illegal opcode, or a fetch from the data region with an illegal opcode) must record only the smallest code.

// File: rtl/bus_guard_pkg.sv
package bus_guard_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_READX = 2'd3
  } bus_kind_e;

  typedef enum logic [2:0] {
    VC_NONE     = 3'd0,
    VC_UNMAPPED = 3'd1,
    VC_WINDOW   = 3'd2,
    VC_FETCH_D  = 3'd3,
    VC_DATA_I   = 3'd4,
    VC_RO_WRITE = 3'd5,
    VC_OPCODE   = 3'd6
  } viol_code_e;

  localparam int NREGION = 4;
  localparam int REG_INSTR  = 0;
  localparam int REG_DATA   = 1;
  localparam int REG_RO     = 2;
  localparam int REG_WINDOW = 3;
  localparam int SEL_W    = 4;
  localparam int SEL_MASK = 8;

  // Lowest set code wins; bit k of pend stands for code k.
  function automatic logic [2:0] pick_code(input logic [7:0] pend);
    logic [2:0] res;
    res = 3'd0;
    for (int k = 7; k >= 1; k--) begin
      if (pend[k]) res = 3'(k);
    end
    return res;
  endfunction

endpackage

// File: rtl/bus_guard_regs.sv
module bus_guard_regs
  import bus_guard_pkg::*;
#(
  parameter int AW  = 16,
  parameter int OPW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_mode,
  input  logic                 cfg_we,
  input  logic [SEL_W-1:0]     cfg_sel,
  input  logic [AW-1:0]        cfg_data,
  output logic [NREGION*AW-1:0] bases,
  output logic [NREGION*AW-1:0] limits,
  output logic [(1<<OPW)-1:0]  op_mask
);
  localparam int MW = 1 << OPW;

  logic load_en;
  assign load_en = cfg_mode && cfg_we;

  for (genvar g = 0; g < NREGION; g++) begin : g_region
    localparam logic [SEL_W-1:0] SEL_BASE  = SEL_W'(2 * g);
    localparam logic [SEL_W-1:0] SEL_LIMIT = SEL_W'(2 * g + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bases[g*AW +: AW]  <= '1;
        limits[g*AW +: AW] <= '0;
      end else if (load_en) begin
        if (cfg_sel == SEL_BASE)  bases[g*AW +: AW]  <= cfg_data;
        if (cfg_sel == SEL_LIMIT) limits[g*AW +: AW] <= cfg_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_mask <= '0;
    end else if (load_en && cfg_sel == SEL_W'(SEL_MASK)) begin
      op_mask <= MW'(cfg_data);
    end
  end

endmodule

// File: rtl/bus_guard_classify.sv
module bus_guard_classify
  import bus_guard_pkg::*;
#(
  parameter int AW  = 16,
  parameter int OPW = 4
) (
  input  logic                  active,
  input  logic [1:0]            kind,
  input  logic [AW-1:0]         addr,
  input  logic [OPW-1:0]        opcode,
  input  logic [NREGION*AW-1:0] bases,
  input  logic [NREGION*AW-1:0] limits,
  input  logic [(1<<OPW)-1:0]   op_mask,
  output logic [7:0]            pend,
  output logic                  viol,
  output logic [2:0]            vcode
);

  function automatic logic in_range(input logic [AW-1:0] a,
                                    input logic [AW-1:0] lo,
                                    input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  logic [NREGION-1:0] hit;
  for (genvar g = 0; g < NREGION; g++) begin : g_hit
    assign hit[g] = in_range(addr, bases[g*AW +: AW], limits[g*AW +: AW]);
  end

  logic is_fetch, is_write, is_data;
  assign is_fetch = (kind == KIND_FETCH);
  assign is_write = (kind == KIND_WRITE);
  assign is_data  = !is_fetch;

  always_comb begin
    pend = 8'd0;
    pend[VC_UNMAPPED] = !(hit[REG_INSTR] || hit[REG_DATA] || hit[REG_RO]);
    pend[VC_WINDOW]   = !hit[REG_WINDOW];
    pend[VC_FETCH_D]  = is_fetch && hit[REG_DATA];
    pend[VC_DATA_I]   = is_data && hit[REG_INSTR];
    pend[VC_RO_WRITE] = is_write && hit[REG_RO];
    pend[VC_OPCODE]   = is_fetch && !op_mask[opcode];
  end

  assign vcode = active ? pick_code(pend) : 3'd0;
  assign viol  = (vcode != 3'd0);

endmodule

// File: rtl/bus_guard_record.sv
module bus_guard_record #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          viol,
  input  logic [2:0]    vcode,
  input  logic [AW-1:0] vaddr,
  input  logic          clear,
  output logic          flag,
  output logic [2:0]    code,
  output logic [AW-1:0] addr,
  output logic          overflow
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      code     <= 3'd0;
      addr     <= '0;
      overflow <= 1'b0;
    end else if (clear) begin
      flag     <= viol;
      code     <= viol ? vcode : 3'd0;
      addr     <= viol ? vaddr : '0;
      overflow <= 1'b0;
    end else if (viol) begin
      if (!flag) begin
        flag <= 1'b1;
        code <= vcode;
        addr <= vaddr;
      end else begin
        overflow <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/bus_guard.sv
module bus_guard
  import bus_guard_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int OPW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_mode,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_sel,
  input  logic [AW-1:0] cfg_data,
  input  logic          bus_valid,
  input  logic [1:0]    bus_kind,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          err_clear,
  output logic          err_flag,
  output logic [2:0]    err_code,
  output logic [AW-1:0] err_addr,
  output logic          err_overflow
);

  logic [NREGION*AW-1:0] bases_w, limits_w;
  logic [(1<<OPW)-1:0]   mask_w;
  logic [7:0]            pend_w;
  logic                  viol_w;
  logic [2:0]            vcode_w;
  logic                  active_w;
  logic [OPW-1:0]        opcode_w;
  logic                  unused_data_bits;

  assign active_w = bus_valid && !cfg_mode;
  assign opcode_w = bus_data[DW-1 -: OPW];
  assign unused_data_bits = ^bus_data[DW-OPW-1:0];

  bus_guard_regs #(.AW(AW), .OPW(OPW)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .bases(bases_w), .limits(limits_w), .op_mask(mask_w)
  );

  bus_guard_classify #(.AW(AW), .OPW(OPW)) cls_i (
    .active(active_w), .kind(bus_kind), .addr(bus_addr), .opcode(opcode_w),
    .bases(bases_w), .limits(limits_w), .op_mask(mask_w),
    .pend(pend_w), .viol(viol_w), .vcode(vcode_w)
  );

  bus_guard_record #(.AW(AW)) rec_i (
    .clk(clk), .rst_n(rst_n), .viol(viol_w), .vcode(vcode_w),
    .vaddr(bus_addr), .clear(err_clear),
    .flag(err_flag), .code(err_code), .addr(err_addr), .overflow(err_overflow)
  );

endmodule

// File: rtl/bus_guard_chk.sv
module bus_guard_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_mode,
  input logic          bus_valid,
  input logic [AW-1:0] bus_addr,
  input logic          err_clear,
  input logic          err_flag,
  input logic [2:0]    err_code,
  input logic [AW-1:0] err_addr,
  input logic          err_overflow,
  input logic          viol_w,
  input logic [2:0]    vcode_w
);

  // R9: flag stays until cleared, first record is frozen
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clear |=> err_flag && $stable(err_code) && $stable(err_addr));

  // R9: first violation captures code and address
  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !err_flag && viol_w && !err_clear |=>
      err_flag && err_code == $past(vcode_w) && err_addr == $past(bus_addr));

  // R9: overflow only with a recorded error
  a_r9_ovf_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |-> err_flag);

  // R10: clear with no new violation empties the record
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    err_clear && !viol_w |=> !err_flag && err_code == 3'd0 && !err_overflow);

  // R11: idle cycles raise nothing
  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !err_flag && !bus_valid |=> !err_flag);

  // R12: no checking in configuration mode
  a_r12_cfg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !err_flag && cfg_mode |=> !err_flag);

  // R1/R9: a set flag always carries a class code
  a_r9_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> err_code != 3'd0);

endmodule

bind bus_guard bus_guard_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .bus_valid(bus_valid),
  .bus_addr(bus_addr), .err_clear(err_clear), .err_flag(err_flag),
  .err_code(err_code), .err_addr(err_addr), .err_overflow(err_overflow),
  .viol_w(viol_w), .vcode_w(vcode_w)
);

// File: tb/bus_guard_tb_top.sv
module bus_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_mode = 1'b0, cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [15:0] cfg_data = '0;
  logic        bus_valid = 1'b0;
  logic [1:0]  bus_kind = '0;
  logic [15:0] bus_addr = '0, bus_data = '0;
  logic        err_clear = 1'b0;
  logic        err_flag, err_overflow;
  logic [2:0]  err_code;
  logic [15:0] err_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .bus_valid(bus_valid),
    .bus_kind(bus_kind), .bus_addr(bus_addr), .bus_data(bus_data),
    .err_clear(err_clear), .err_flag(err_flag), .err_code(err_code),
    .err_addr(err_addr), .err_overflow(err_overflow)
  );

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic expect_rec(string req, bit f, logic [2:0] c, logic [15:0] a, bit o);
    chk(req, "flag", 16'(err_flag), 16'(f));
    chk(req, "code", 16'(err_code), 16'(c));
    chk(req, "addr", err_addr, a);
    chk(req, "overflow", 16'(err_overflow), 16'(o));
  endtask

  task automatic cfg_write(logic [3:0] sel, logic [15:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic bus(logic [1:0] kind, logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_kind = kind; bus_addr = a; bus_data = d;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic clear_err();
    @(negedge clk);
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
  endtask

  task automatic configure(logic [15:0] win_hi);
    @(negedge clk); cfg_mode = 1'b1;
    cfg_write(4'd0, 16'h0000); cfg_write(4'd1, 16'h0FFF);
    cfg_write(4'd2, 16'h2000); cfg_write(4'd3, 16'h2FFF);
    cfg_write(4'd4, 16'h4000); cfg_write(4'd5, 16'h40FF);
    cfg_write(4'd6, 16'h0000); cfg_write(4'd7, win_hi);
    cfg_write(4'd8, 16'h00FF);
    @(negedge clk); cfg_mode = 1'b0;
  endtask

  task automatic t_reset();
    expect_rec("R1", 0, 3'd0, 16'h0, 0);
  endtask

  task automatic t_legal();
    bus(2'd0, 16'h0100, 16'h1234);
    bus(2'd1, 16'h2010, 16'h0);
    bus(2'd1, 16'h4000, 16'h0);
    bus(2'd2, 16'h2020, 16'hFFFF);
    expect_rec("R5 legal traffic", 0, 3'd0, 16'h0, 0);
  endtask

  task automatic t_single(string req, logic [1:0] k, logic [15:0] a,
                          logic [15:0] d, logic [2:0] c);
    bus(k, a, d);
    expect_rec(req, 1, c, a, 0);
    clear_err();
    expect_rec({req, " after clear"}, 0, 3'd0, 16'h0, 0);
  endtask

  task automatic t_sticky();
    bus(2'd0, 16'h2004, 16'h1000);
    bus(2'd2, 16'h0008, 16'h0);
    expect_rec("R9 sticky", 1, 3'd3, 16'h2004, 1);
  endtask

  task automatic t_clear_same_cycle();
    @(negedge clk);
    err_clear = 1'b1; bus_valid = 1'b1; bus_kind = 2'd2;
    bus_addr = 16'h4010; bus_data = 16'h0;
    @(negedge clk);
    err_clear = 1'b0; bus_valid = 1'b0;
    expect_rec("R10 clear+violation", 1, 3'd5, 16'h4010, 0);
    clear_err();
  endtask

  task automatic t_idle();
    @(negedge clk);
    bus_valid = 1'b0; bus_kind = 2'd0; bus_addr = 16'h9999; bus_data = 16'hF000;
    repeat (3) @(negedge clk);
    expect_rec("R11 idle", 0, 3'd0, 16'h0, 0);
  endtask

  task automatic t_cfg();
    cfg_write(4'd0, 16'h1000);
    bus(2'd0, 16'h0100, 16'h1000);
    expect_rec("R12 cfg_we ignored in monitor mode", 0, 3'd0, 16'h0, 0);
    @(negedge clk); cfg_mode = 1'b1;
    bus(2'd0, 16'h9000, 16'hF000);
    @(negedge clk); cfg_mode = 1'b0;
    expect_rec("R12 no check in cfg mode", 0, 3'd0, 16'h0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    configure(16'h7FFF);
    t_legal();
    t_single("R2", 2'd0, 16'h2004, 16'h1000, 3'd3);
    t_single("R3 write", 2'd2, 16'h0010, 16'h0, 3'd4);
    t_single("R3 read", 2'd3, 16'h0FFF, 16'h0, 3'd4);
    t_single("R4", 2'd1, 16'h3000, 16'h0, 3'd1);
    t_single("R5", 2'd2, 16'h40FF, 16'h0, 3'd5);
    t_single("R6", 2'd0, 16'h0200, 16'h9000, 3'd6);
    t_single("R8 unmapped over window/opcode", 2'd0, 16'h8000, 16'hF000, 3'd1);
    t_single("R8 fetch-data over opcode", 2'd0, 16'h2000, 16'h9000, 3'd3);
    t_idle();
    t_cfg();
    t_sticky();
    t_clear_same_cycle();
    configure(16'h3FFF);
    t_single("R7", 2'd1, 16'h4000, 16'h0, 3'd2);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule